// File: doc/BRIEF.md
# Multi-Form Integer Multiply Unit

This block is a pipelined integer multiplier for an execution pipeline. It supports three operating forms. The widening form multiplies an accumulator operand by a second operand and returns the double-width product as separate high and low halves. The truncating form multiplies two register operands and keeps only the destination-sized low part. The immediate form multiplies one register operand by a sign-extended immediate and also keeps only the low part. A select picks the operand size (8, 16 or 32 bits). A signed/unsigned select applies to the widening form only.

The unit also reports a carry flag and an overflow flag, which always carry the same value. They are set when significant bits of the product do not fit where the form places them. An operation is taken when `inValid` and `inReady` are both high, and one new operation can be taken every cycle. The result appears with a single-cycle `outValid` pulse exactly two cycles after the accepting edge. There is no output back-pressure.

Top module: `multiform_mul`

## Requirements
- R1: `sizeSel` selects the operand size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 behaves as 32 bits. Operand bits above the selected size are ignored. Result bits above the selected placement are zero. In the widening form (`formSel`=0), an 8-bit operation returns the whole 16-bit product on `resLo` with `resHi` zero. A 16-bit operation returns the product's low 16 bits in `resLo[15:0]` and its high 16 bits in `resHi[15:0]`. A 32-bit operation returns the low 32 bits on `resLo` and the high 32 bits on `resHi`.
- R2: In the widening form, `isSigned`=1 treats both operands as two's complement and `isSigned`=0 treats them as unsigned. The low half of the product is the same in both modes and only the high half differs.
- R3: The truncating form (`formSel`=1, with 3 as an alias) returns the low operand-size bits of the signed product `opA`×`opB` on `resLo`, with `resHi` zero. `isSigned` has no effect on its result or flags.
- R4: The immediate form (`formSel`=2) multiplies `opA` by the 16-bit `immVal` sign-extended to the operand size. It places its result and flags in the same way as R3.
- R5: In the truncating and immediate forms, both flags are set when the signed product does not fit in the operand size. Both flags are cleared when it fits.
- R6: In the signed widening form, both flags are set when the high half is not the sign extension of the low half, and cleared otherwise. For example, signed 8-bit 48×4 gives 0x00C0 with the flags set.
- R7: In the unsigned widening form, both flags are set exactly when the high half of the product is nonzero.
- R8: `carryFlag` and `overflowFlag` are always equal for a completed operation.
- R9: An operation accepted on a clock edge raises `outValid` for one cycle after the second following edge. Operations may be accepted on every cycle, and each one completes in order.
- R10: While `rst` is high, `inReady` and `outValid` are low. An operation accepted just before reset never produces an `outValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation request |
| inReady | output | 1 | Unit can take an operation (low in reset) |
| formSel | input | 2 | 0 widening, 1 truncating, 2 immediate, 3 truncating |
| sizeSel | input | 2 | 0 byte, 1 half, 2 word, 3 word |
| isSigned | input | 1 | Signed mode for the widening form |
| opA | input | DATA_W | Accumulator or first register operand |
| opB | input | DATA_W | Second register operand |
| immVal | input | IMM_W | Immediate for the immediate form |
| outValid | output | 1 | Result valid pulse |
| resLo | output | DATA_W | Low result half |
| resHi | output | DATA_W | High result half (widening only) |
| carryFlag | output | 1 | Significant bits lost or placed high |
| overflowFlag | output | 1 | Same as carryFlag |

## Verification
The bench builds the unit with its default widths, a 32-bit datapath and a 16-bit immediate. These widths make all three operand sizes reachable, including the 32-bit widening case whose product fills the full 64-bit high and low pair. The 16-bit immediate lets a negative immediate be truncated to a byte and then sign-extended from bit 7. The stimulus drives garbage in unused upper operand bits. It also runs a back-to-back stream of mixed forms and sizes, and resets the unit while an operation is in flight.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    FORM_WIDE    = 2'd0,
    FORM_TWO     = 2'd1,
    FORM_IMM     = 2'd2,
    FORM_TWO_ALT = 2'd3
  } mfmForm_e;

  typedef enum logic [1:0] {
    SZ_8      = 2'd0,
    SZ_16     = 2'd1,
    SZ_32     = 2'd2,
    SZ_32_ALT = 2'd3
  } mfmSize_e;

  // load strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic s3Load;
  } mfmStrobe_t;

endpackage

// File: rtl/mfm_ctrl.sv
module mfm_ctrl
  import mfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  output mfmStrobe_t strobe,
  output logic       outValid
);

  logic accept;
  logic stage1Vld;
  logic stage2Vld;
  logic stage3Vld;

  assign inReady = !rst;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Vld <= 1'b0;
      stage2Vld <= 1'b0;
      stage3Vld <= 1'b0;
    end else begin
      stage1Vld <= accept;
      stage2Vld <= stage1Vld;
      stage3Vld <= stage2Vld;
    end
  end

  always_comb begin
    strobe.s1Load = accept;
    strobe.s2Load = stage1Vld;
    strobe.s3Load = stage2Vld;
  end

  assign outValid = stage3Vld;

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (outValid == $past(inValid && inReady, 3))); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R10

endmodule

// File: rtl/mfm_datapath.sv
module mfm_datapath
  import mfm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  mfmStrobe_t        strobe,
  input  mfmForm_e          formSel,
  input  mfmSize_e          sizeSel,
  input  logic              isSigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              carryFlag,
  output logic              overflowFlag
);

  localparam int EXT_W  = DATA_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int W8     = DATA_W / 4;
  localparam int W16    = DATA_W / 2;
  localparam int NSIZE  = 3;

  // widen an operand by one bit, sign- or zero-extended from the chosen size
  function automatic logic [EXT_W-1:0] extendOp(input logic [DATA_W-1:0] v,
                                                input mfmSize_e sz,
                                                input logic sgn);
    logic [EXT_W-1:0] r;
    case (sz)
      SZ_8:    r = {{(EXT_W-W8){sgn & v[W8-1]}}, v[W8-1:0]};
      SZ_16:   r = {{(EXT_W-W16){sgn & v[W16-1]}}, v[W16-1:0]};
      default: r = {sgn & v[DATA_W-1], v};
    endcase
    return r;
  endfunction

  // ---------------- stage 1: operand conditioning ----------------
  logic              isWide;
  logic              effSigned;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] srcB;

  assign isWide    = (formSel == FORM_WIDE);
  assign effSigned = isWide ? isSigned : 1'b1;
  assign immExt    = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign srcB      = (formSel == FORM_IMM) ? immExt : opB;

  logic [EXT_W-1:0] s1A;
  logic [EXT_W-1:0] s1B;
  logic             s1Wide;
  logic             s1Sgn;
  mfmSize_e         s1Size;

  always_ff @(posedge clk) begin
    if (strobe.s1Load) begin
      s1A    <= extendOp(opA, sizeSel, effSigned);
      s1B    <= extendOp(srcB, sizeSel, effSigned);
      s1Wide <= isWide;
      s1Sgn  <= effSigned;
      s1Size <= sizeSel;
    end
  end

  // ---------------- stage 2: full signed multiply ----------------
  logic signed [PROD_W-1:0] prodFull;
  assign prodFull = $signed(s1A) * $signed(s1B);

  logic [PROD_W-1:0] s2Prod;
  logic              s2Wide;
  logic              s2Sgn;
  mfmSize_e          s2Size;

  always_ff @(posedge clk) begin
    if (strobe.s2Load) begin
      s2Prod <= prodFull;
      s2Wide <= s1Wide;
      s2Sgn  <= s1Sgn;
      s2Size <= s1Size;
    end
  end

  // ---------------- stage 3: per-size placement and loss flags ----------------
  logic [NSIZE-1:0][DATA_W-1:0] candLo;
  logic [NSIZE-1:0][DATA_W-1:0] candHi;
  logic [NSIZE-1:0]             candLost;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W = DATA_W >> (NSIZE - 1 - g);
    logic [W:0] signSpan;
    logic       lostSigned;
    logic       lostUnsigned;

    assign signSpan     = s2Prod[2*W-1:W-1];
    assign lostSigned   = !((&signSpan) || !(|signSpan));
    assign lostUnsigned = |s2Prod[2*W-1:W];
    assign candLost[g]  = s2Sgn ? lostSigned : lostUnsigned;

    if (g == 0) begin : g_byte
      assign candLo[g] = s2Wide ? {{(DATA_W-2*W){1'b0}}, s2Prod[2*W-1:0]}
                                : {{(DATA_W-W){1'b0}}, s2Prod[W-1:0]};
      assign candHi[g] = '0;
    end else if (g == NSIZE - 1) begin : g_full
      assign candLo[g] = s2Prod[W-1:0];
      assign candHi[g] = s2Wide ? s2Prod[2*W-1:W] : '0;
    end else begin : g_mid
      assign candLo[g] = {{(DATA_W-W){1'b0}}, s2Prod[W-1:0]};
      assign candHi[g] = s2Wide ? {{(DATA_W-W){1'b0}}, s2Prod[2*W-1:W]} : '0;
    end
  end

  logic [1:0] sizeIdx;
  always_comb begin
    case (s2Size)
      SZ_8:    sizeIdx = 2'd0;
      SZ_16:   sizeIdx = 2'd1;
      default: sizeIdx = 2'd2;
    endcase
  end

  logic [DATA_W-1:0] resLoQ;
  logic [DATA_W-1:0] resHiQ;
  logic              carryQ;
  logic              ovfQ;
  logic              s3Wide;
  logic              s3Sgn;
  mfmSize_e          s3Size;

  always_ff @(posedge clk) begin
    if (strobe.s3Load) begin
      resLoQ <= candLo[sizeIdx];
      resHiQ <= candHi[sizeIdx];
      carryQ <= candLost[sizeIdx];
      ovfQ   <= candLost[sizeIdx];
      s3Wide <= s2Wide;
      s3Sgn  <= s2Sgn;
      s3Size <= s2Size;
    end
  end

  assign resLo        = resLoQ;
  assign resHi        = resHiQ;
  assign carryFlag    = carryQ;
  assign overflowFlag = ovfQ;

  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.s2Load) |-> (s2Prod[PROD_W-1] == s2Prod[PROD_W-2])); // R1

  AST_TRUNC_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.s3Load) && !s3Wide) |-> (resHi == '0)); // R3

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.s3Load) && s3Size == SZ_8) |-> (resHi == '0 && resLo[DATA_W-1:2*W8] == '0)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.s3Load) && s3Wide && !s3Sgn && s3Size != SZ_8) |-> (carryQ == (resHi != '0))); // R7

  AST_SIGNED_WIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.s3Load) && s3Wide && s3Sgn && (s3Size == SZ_32 || s3Size == SZ_32_ALT))
      |-> (ovfQ == (resHi != {DATA_W{resLo[DATA_W-1]}}))); // R6

endmodule

// File: rtl/multiform_mul.sv
module multiform_mul
  import mfm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        formSel,
  input  logic [1:0]        sizeSel,
  input  logic              isSigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  output logic              outValid,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              carryFlag,
  output logic              overflowFlag
);

  mfmStrobe_t strobe;

  mfm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mfm_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .formSel      (mfmForm_e'(formSel)),
    .sizeSel      (mfmSize_e'(sizeSel)),
    .isSigned     (isSigned),
    .opA          (opA),
    .opB          (opB),
    .immVal       (immVal),
    .resLo        (resLo),
    .resHi        (resHi),
    .carryFlag    (carryFlag),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: tb/multiform_mul_bench.sv
module multiform_mul_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPIPE      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  formSel = '0;
  logic [1:0]  sizeSel = '0;
  logic        isSigned = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] immVal = '0;
  logic        outValid;
  logic [31:0] resLo;
  logic [31:0] resHi;
  logic        carryFlag;
  logic        overflowFlag;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multiform_mul u_multiform_mul (
    .clk (clk), .rst (rst), .inValid (inValid), .inReady (inReady),
    .formSel (formSel), .sizeSel (sizeSel), .isSigned (isSigned),
    .opA (opA), .opB (opB), .immVal (immVal),
    .outValid (outValid), .resLo (resLo), .resHi (resHi),
    .carryFlag (carryFlag), .overflowFlag (overflowFlag)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint extendVal(input logic [63:0] v, input int w, input bit s);
    longint m;
    longint r;
    m = (longint'(1) << w) - 1;
    r = longint'(v) & m;
    if (s && r[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  // independent reference computed from the requirements
  task automatic model(input int form, input bit sgn, input int size,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                       output logic [31:0] lo, output logic [31:0] hi, output bit flag);
    int          w;
    bit          wide;
    bit          s;
    logic [31:0] bb;
    longint      m;
    longint      p;
    logic [63:0] pl;
    w    = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    wide = (form == 0);
    s    = wide ? sgn : 1'b1;
    bb   = (form == 2) ? {{16{imm[15]}}, imm} : b;
    m    = (longint'(1) << w) - 1;
    p    = extendVal(a, w, s) * extendVal(bb, w, s);
    pl   = p;
    if (s) flag = (extendVal(pl, w, 1'b1) != p);
    else   flag = (((pl >> w) & m) != 0);
    if (wide && w == 8) begin
      lo = {16'h0, pl[15:0]};
      hi = '0;
    end else if (wide) begin
      lo = 32'(pl & m);
      hi = 32'((pl >> w) & m);
    end else begin
      lo = 32'(pl & m);
      hi = '0;
    end
  endtask

  task automatic runOp(input string req, input int form, input bit sgn, input int size,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] eLo;
    logic [31:0] eHi;
    bit          eF;
    model(form, sgn, size, a, b, imm, eLo, eHi, eF);
    @(negedge clk);
    formSel = 2'(form); sizeSel = 2'(size); isSigned = sgn;
    opA = a; opB = b; immVal = imm; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R9", "outValid one cycle after accept", {63'd0, outValid}, 64'd0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "outValid at latency", {63'd0, outValid}, 64'd1);
    chk(req, "resLo", {32'd0, resLo}, {32'd0, eLo});
    chk(req, "resHi", {32'd0, resHi}, {32'd0, eHi});
    chk(req, "carryFlag", {63'd0, carryFlag}, {63'd0, eF});
    chk("R8", "overflowFlag equals carryFlag", {63'd0, overflowFlag}, {63'd0, carryFlag});
    @(posedge clk);
    @(negedge clk);
    chk("R9", "outValid single pulse", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R10", "inReady in reset", {63'd0, inReady}, 64'd0);
    chk("R10", "outValid in reset", {63'd0, outValid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "inReady after reset", {63'd0, inReady}, 64'd1);
  endtask

  task automatic testWidening();
    runOp("R6", 0, 1'b1, 0, 32'h0000_0030, 32'h0000_0004, 16'h0);  // 48*4 byte signed
    runOp("R1", 0, 1'b0, 0, 32'hABCD_00FF, 32'h1234_56FF, 16'h0);  // upper garbage ignored
    runOp("R2", 0, 1'b1, 1, 32'h0000_FFFE, 32'h0000_0003, 16'h0);
    runOp("R2", 0, 1'b0, 1, 32'h0000_FFFE, 32'h0000_0003, 16'h0);
    runOp("R7", 0, 1'b0, 1, 32'h0000_0064, 32'h0000_00C8, 16'h0);  // fits, no flag
    runOp("R2", 0, 1'b0, 2, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0);
    runOp("R6", 0, 1'b1, 2, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0);
    runOp("R1", 0, 1'b1, 3, 32'h8000_0000, 32'h8000_0000, 16'h0);  // size 3 = 32
  endtask

  task automatic testTruncating();
    runOp("R5", 1, 1'b0, 1, 32'h0000_012C, 32'h0000_012C, 16'h0);  // 300*300 lost
    runOp("R3", 1, 1'b1, 1, 32'h0000_012C, 32'h0000_012C, 16'h0);  // isSigned no effect
    runOp("R3", 1, 1'b0, 0, 32'h0000_00FF, 32'h0000_0002, 16'h0);  // -1*2 fits
    runOp("R5", 1, 1'b0, 2, 32'h0001_0000, 32'h0001_0000, 16'h0);
    runOp("R5", 3, 1'b0, 2, 32'h0000_04D2, 32'h0000_162E, 16'h0);  // alias, fits
    runOp("R3", 3, 1'b1, 0, 32'h5555_0010, 32'hAAAA_0009, 16'h0);
  endtask

  task automatic testImmediate();
    runOp("R4", 2, 1'b0, 2, 32'h0000_03E8, 32'hDEAD_BEEF, 16'hFFFF);  // 1000*-1
    runOp("R4", 2, 1'b0, 0, 32'h0000_0003, 32'h0, 16'h0080);          // imm byte -128
    runOp("R5", 2, 1'b1, 1, 32'h0000_7FFF, 32'h0, 16'h0002);
  endtask

  task automatic testPipeline();
    int          pForm[NPIPE];
    bit          pSgn[NPIPE];
    int          pSize[NPIPE];
    logic [31:0] pA[NPIPE];
    logic [31:0] pB[NPIPE];
    logic [15:0] pImm[NPIPE];
    logic [31:0] eLo[NPIPE];
    logic [31:0] eHi[NPIPE];
    bit          eF[NPIPE];
    for (int k = 0; k < NPIPE; k++) begin
      pForm[k] = k % 4;
      pSgn[k]  = k[0];
      pSize[k] = (k / 2) % 4;
      pA[k]    = 32'h1357_9BDF * (k + 3);
      pB[k]    = 32'h2468_ACE0 + 32'(k * 77);
      pImm[k]  = 16'h8001 + 16'(k * 301);
      model(pForm[k], pSgn[k], pSize[k], pA[k], pB[k], pImm[k], eLo[k], eHi[k], eF[k]);
    end
    for (int i = 0; i < NPIPE + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R9", "back-to-back outValid", {63'd0, outValid}, 64'd1);
        chk("R9", "back-to-back resLo", {32'd0, resLo}, {32'd0, eLo[i-3]});
        chk("R9", "back-to-back resHi", {32'd0, resHi}, {32'd0, eHi[i-3]});
        chk("R9", "back-to-back flag", {63'd0, carryFlag}, {63'd0, eF[i-3]});
      end else begin
        chk("R9", "idle before stream", {63'd0, outValid}, 64'd0);
      end
      if (i < NPIPE) begin
        formSel = 2'(pForm[i]); sizeSel = 2'(pSize[i]); isSigned = pSgn[i];
        opA = pA[i]; opB = pB[i]; immVal = pImm[i]; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R9", "stream drained", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testFlush();
    @(negedge clk);
    formSel = 2'd0; sizeSel = 2'd2; isSigned = 1'b0;
    opA = 32'h0000_0005; opB = 32'h0000_0007; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "inReady during flush reset", {63'd0, inReady}, 64'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R10", "no output during reset", {63'd0, outValid}, 64'd0);
    end
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10", "flushed op never appears", {63'd0, outValid}, 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testWidening();
    testTruncating();
    testImmediate();
    testPipeline();
    testFlush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule